// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic Unit With Overflow Register

This block carries out the two-operand basic operations of a small 16-bit processor. An external decoder presents a 4-bit opcode and the two already fetched operand values, `opA` and `opB`. It raises `issue` for the one cycle in which the instruction executes. In that same cycle the block returns the value to write back, a write enable, a skip request for the conditional tests and the fixed cycle cost of the opcode. All of these outputs are combinational.

The only state the block owns is the overflow register. It is loaded on the clock edge that closes an issued add, subtract, multiply, divide or shift, and it holds its value across every other opcode. The carry of an add, the borrow of a subtract, the high product half, the fractional quotient and the bits shifted out all land in this register, each in its own encoding. Division and modulo by zero both give zero instead of trapping.

Top module: `ovf_alu`

## Requirements
- R1: While `rstN` is low, the overflow register is cleared to 0x0000, and it reads 0x0000 on the first cycle after release.
- R2: ADD (opcode 0x2) writes the low 16 bits of a+b and loads 0x0001 into the overflow register on a carry out of bit 15, otherwise 0x0000. Its cost is 2.
- R3: SUB (opcode 0x3) writes a-b modulo 2^16 and loads 0xFFFF on a borrow (b greater than a, unsigned), otherwise 0x0000. Its cost is 2.
- R4: MUL (opcode 0x4) writes bits 15:0 of the unsigned 32-bit product and loads bits 31:16 of it. Its cost is 2.
- R5: DIV (opcode 0x5) writes the unsigned quotient a/b and loads bits 15:0 of (a*65536)/b. When b is zero, both the written value and the loaded value are 0x0000. Its cost is 3.
- R6: MOD (opcode 0x6) writes a%b, or 0x0000 when b is zero. Its cost is 3, and the overflow register keeps its value.
- R7: SHL (opcode 0x7) writes bits 15:0 of a shifted left by b inside 32 bits and loads bits 31:16 of that shift. A shift of 32 or more gives zero in both.
- R8: SHR (opcode 0x8) writes a>>b and loads bits 15:0 of (a*65536)>>b, taking the original a. Its cost is 2.
- R9: SET (0x1) writes b, AND (0x9) writes a&b, BOR (0xA) writes a|b and XOR (0xB) writes a^b. Each costs 1 and leaves the overflow register unchanged.
- R10: IFE (0xC), IFN (0xD), IFG (0xE) and IFB (0xF) raise `skipNext` when, respectively, a==b, a!=b, a>b (unsigned) or (a&b)==0. They never write, present 0x0000 on `result`, cost 2 and leave the overflow register unchanged.
- R11: Opcode 0x0 is the non-basic escape: no write, no skip, cost 0, `result` 0x0000, and the overflow register is unchanged.
- R12: With `issue` low, `resultWe` and `skipNext` are low and the overflow register holds. `result` and `cycleCost` still follow the presented opcode and operands.
- R13: For an issued instruction, `result`, `resultWe`, `skipNext` and `cycleCost` are valid in the issue cycle, and the overflow update is visible on `ovf` right after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Execute the presented instruction this cycle |
| opcode | input | 4 | Basic operation code |
| opA | input | 16 | First operand value (destination value) |
| opB | input | 16 | Second operand value |
| result | output | 16 | Value to write back |
| resultWe | output | 1 | Write-back enable |
| ovf | output | 16 | Overflow register |
| cycleCost | output | 2 | Cycle cost of the presented opcode |
| skipNext | output | 1 | Request to skip the following instruction |

## Verification
The overflow register is the only internal state. A wrong value loaded into it, or a load on an opcode that should hold it, shows on `ovf` right after the clock edge that closes the instruction. The wrong value then stays on the port until the next arithmetic opcode overwrites it. For that reason each hold check runs after a known non-zero value has been loaded. Decode errors in the write enable, the skip request or the cost table show on the ports within the issue cycle, with no latency.

// File: rtl/aou_pkg.sv
package aou_pkg;

  localparam int unsigned OPC_W  = 4;
  localparam int unsigned COST_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OPC_ESC = 4'h0,
    OPC_SET = 4'h1,
    OPC_ADD = 4'h2,
    OPC_SUB = 4'h3,
    OPC_MUL = 4'h4,
    OPC_DIV = 4'h5,
    OPC_MOD = 4'h6,
    OPC_SHL = 4'h7,
    OPC_SHR = 4'h8,
    OPC_AND = 4'h9,
    OPC_BOR = 4'hA,
    OPC_XOR = 4'hB,
    OPC_IFE = 4'hC,
    OPC_IFN = 4'hD,
    OPC_IFG = 4'hE,
    OPC_IFB = 4'hF
  } opcode_e;

  // fixed cycle cost classes
  localparam logic [COST_W-1:0] COST_NONE  = 2'd0;
  localparam logic [COST_W-1:0] COST_LOGIC = 2'd1;
  localparam logic [COST_W-1:0] COST_ARITH = 2'd2;
  localparam logic [COST_W-1:0] COST_LONG  = 2'd3;
  localparam logic [COST_W-1:0] COST_TEST  = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    opcode_e             fn;
    logic                writeRes;
    logic                loadOvf;
    logic                isTest;
    logic [COST_W-1:0]   cost;
  } strobe_t;

endpackage

// File: rtl/aou_ctrl.sv
module aou_ctrl
  import aou_pkg::*;
(
  input  logic    issue,
  input  opcode_e opc,
  output strobe_t strb
);

  always_comb begin
    strb.fn       = opc;
    strb.writeRes = 1'b0;
    strb.loadOvf  = 1'b0;
    strb.isTest   = 1'b0;
    strb.cost     = COST_NONE;
    case (opc)
      OPC_SET, OPC_AND, OPC_BOR, OPC_XOR: begin
        strb.writeRes = issue;
        strb.cost     = COST_LOGIC;
      end
      OPC_ADD, OPC_SUB, OPC_MUL, OPC_SHL, OPC_SHR: begin
        strb.writeRes = issue;
        strb.loadOvf  = issue;
        strb.cost     = COST_ARITH;
      end
      OPC_DIV: begin
        strb.writeRes = issue;
        strb.loadOvf  = issue;
        strb.cost     = COST_LONG;
      end
      OPC_MOD: begin
        strb.writeRes = issue;
        strb.cost     = COST_LONG;
      end
      OPC_IFE, OPC_IFN, OPC_IFG, OPC_IFB: begin
        strb.isTest = issue;
        strb.cost   = COST_TEST;
      end
      default: begin
        strb.cost = COST_NONE;
      end
    endcase
  end

endmodule

// File: rtl/aou_datapath.sv
module aou_datapath
  import aou_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic [W-1:0] ovfQ,
  output logic         condMet
);

  localparam int unsigned WW = 2 * W;
  localparam logic [W-1:0] ZERO_W = '0;
  localparam logic [W-1:0] ONES_W = '1;
  localparam logic [W-1:0] ONE_W  = W'(1);

  logic [W:0]    sumX;
  logic [W:0]    diffX;
  logic [WW-1:0] prodX;
  logic [WW-1:0] shlX;
  logic          bIsZero;
  logic [W-1:0]  ovfNext;

  assign sumX    = {1'b0, a} + {1'b0, b};
  assign diffX   = {1'b0, a} - {1'b0, b};
  assign prodX   = {ZERO_W, a} * {ZERO_W, b};
  assign shlX    = {ZERO_W, a} << b;
  assign bIsZero = (b == ZERO_W);

  // result and overflow candidate
  always_comb begin
    res     = ZERO_W;
    ovfNext = ovfQ;
    case (strb.fn)
      OPC_SET: res = b;
      OPC_ADD: begin
        res     = sumX[W-1:0];
        ovfNext = sumX[W] ? ONE_W : ZERO_W;
      end
      OPC_SUB: begin
        res     = diffX[W-1:0];
        ovfNext = diffX[W] ? ONES_W : ZERO_W;
      end
      OPC_MUL: begin
        res     = prodX[W-1:0];
        ovfNext = prodX[WW-1:W];
      end
      OPC_DIV: begin
        res     = bIsZero ? ZERO_W : (a / b);
        ovfNext = bIsZero ? ZERO_W : W'({a, ZERO_W} / {ZERO_W, b});
      end
      OPC_MOD: res = bIsZero ? ZERO_W : (a % b);
      OPC_SHL: begin
        res     = shlX[W-1:0];
        ovfNext = shlX[WW-1:W];
      end
      OPC_SHR: begin
        res     = a >> b;
        ovfNext = W'({a, ZERO_W} >> b);
      end
      OPC_AND: res = a & b;
      OPC_BOR: res = a | b;
      OPC_XOR: res = a ^ b;
      default: res = ZERO_W;
    endcase
  end

  // conditional tests
  always_comb begin
    case (strb.fn)
      OPC_IFE: condMet = (a == b);
      OPC_IFN: condMet = (a != b);
      OPC_IFG: condMet = (a > b);
      OPC_IFB: condMet = ((a & b) == ZERO_W);
      default: condMet = 1'b0;
    endcase
  end

  // overflow register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfQ <= ZERO_W;
    end else if (strb.loadOvf) begin
      ovfQ <= ovfNext;
    end
  end

endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import aou_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issue,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [DATA_W-1:0] ovf,
  output logic [COST_W-1:0] cycleCost,
  output logic              skipNext
);

  strobe_t strb;
  logic    condMet;

  aou_ctrl u_ctrl (
    .issue (issue),
    .opc   (opcode_e'(opcode)),
    .strb  (strb)
  );

  aou_datapath #(.W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .a       (opA),
    .b       (opB),
    .res     (result),
    .ovfQ    (ovf),
    .condMet (condMet)
  );

  assign resultWe  = strb.writeRes;
  assign skipNext  = strb.isTest & condMet;
  assign cycleCost = strb.cost;

endmodule

// File: rtl/aou_props.sv
module aou_props #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         issue,
  input logic [3:0]   opcode,
  input logic [W-1:0] opA,
  input logic [W-1:0] opB,
  input logic [W-1:0] result,
  input logic         resultWe,
  input logic [W-1:0] ovf,
  input logic [1:0]   cycleCost,
  input logic         skipNext
);

  logic [W:0] addWide;
  assign addWide = {1'b0, opA} + {1'b0, opB};

  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rstN) |-> (ovf == '0));

  a_r2_add_carry: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h2) |=> (ovf == ($past(addWide[W]) ? W'(1) : W'(0))));

  a_r3_sub_borrow: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h3) |=> (ovf == ($past(opB > opA) ? {W{1'b1}} : W'(0))));

  a_r4_mul_low: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h4) |-> (result == W'(opA * opB)));

  a_r5_div_zero_res: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h5 && opB == '0) |-> (result == '0 && resultWe));

  a_r5_div_zero_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h5 && opB == '0) |=> (ovf == '0));

  a_r6_mod_hold: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h6) |=> $stable(ovf));

  a_r10_test_nowrite: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode >= 4'hC) |-> (!resultWe && cycleCost == 2'd2));

  a_r11_escape: assert property (@(posedge clk) disable iff (!rstN)
    (issue && opcode == 4'h0) |-> (!resultWe && !skipNext && cycleCost == 2'd0));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !issue |-> (!resultWe && !skipNext));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> $stable(ovf));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(resultWe && skipNext));

endmodule

bind ovf_alu aou_props #(.W(DATA_W)) u_props (
  .clk       (clk),
  .rstN      (rstN),
  .issue     (issue),
  .opcode    (opcode),
  .opA       (opA),
  .opB       (opB),
  .result    (result),
  .resultWe  (resultWe),
  .ovf       (ovf),
  .cycleCost (cycleCost),
  .skipNext  (skipNext)
);

// File: tb/ovf_alu_test.sv
`timescale 1ns/1ps
module ovf_alu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opcode = 4'h0;
  logic [15:0] opA = 16'h0;
  logic [15:0] opB = 16'h0;
  logic [15:0] result;
  logic        resultWe;
  logic [15:0] ovf;
  logic [1:0]  cycleCost;
  logic        skipNext;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ovf_alu uut (
    .clk       (clk),
    .rstN      (rstN),
    .issue     (issue),
    .opcode    (opcode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .resultWe  (resultWe),
    .ovf       (ovf),
    .cycleCost (cycleCost),
    .skipNext  (skipNext)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then ovf after the edge
  task automatic runOp(input string tag, input logic iss, input logic [3:0] op,
                       input logic [15:0] a, input logic [15:0] b,
                       input logic [15:0] expRes, input logic expWe,
                       input logic expSkip, input logic [1:0] expCost,
                       input logic [15:0] expOvf);
    @(negedge clk);
    issue = iss; opcode = op; opA = a; opB = b;
    #2;
    check(tag, "result", result, expRes);
    check(tag, "resultWe", {15'h0, resultWe}, {15'h0, expWe});
    check(tag, "skipNext", {15'h0, skipNext}, {15'h0, expSkip});
    check(tag, "cycleCost", {14'h0, cycleCost}, {14'h0, expCost});
    @(posedge clk);
    #1;
    check(tag, "ovf", ovf, expOvf);
    issue = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R1", "ovf after reset", ovf, 16'h0000);
    check("R12", "resultWe idle", {15'h0, resultWe}, 16'h0);
    check("R12", "skipNext idle", {15'h0, skipNext}, 16'h0);
  endtask

  task automatic testAdd();
    runOp("R2", 1, 4'h2, 16'hFFFF, 16'h0002, 16'h0001, 1, 0, 2'd2, 16'h0001);
    runOp("R2", 1, 4'h2, 16'h1234, 16'h1111, 16'h2345, 1, 0, 2'd2, 16'h0000);
  endtask

  task automatic testSub();
    runOp("R3", 1, 4'h3, 16'h0005, 16'h0007, 16'hFFFE, 1, 0, 2'd2, 16'hFFFF);
    runOp("R3", 1, 4'h3, 16'h9000, 16'h1000, 16'h8000, 1, 0, 2'd2, 16'h0000);
  endtask

  task automatic testMul();
    runOp("R4", 1, 4'h4, 16'h1234, 16'h0100, 16'h3400, 1, 0, 2'd2, 16'h0012);
    runOp("R4", 1, 4'h4, 16'hFFFF, 16'hFFFF, 16'h0001, 1, 0, 2'd2, 16'hFFFE);
  endtask

  task automatic testDiv();
    runOp("R5", 1, 4'h5, 16'h0007, 16'h0002, 16'h0003, 1, 0, 2'd3, 16'h8000);
    runOp("R5", 1, 4'h5, 16'h0001, 16'h0003, 16'h0000, 1, 0, 2'd3, 16'h5555);
    runOp("R5", 1, 4'h5, 16'h1234, 16'h0000, 16'h0000, 1, 0, 2'd3, 16'h0000);
  endtask

  task automatic testMod();
    runOp("R6", 1, 4'h2, 16'hFFFF, 16'h0002, 16'h0001, 1, 0, 2'd2, 16'h0001);
    runOp("R6", 1, 4'h6, 16'h0011, 16'h0005, 16'h0002, 1, 0, 2'd3, 16'h0001);
    runOp("R6", 1, 4'h6, 16'h1234, 16'h0000, 16'h0000, 1, 0, 2'd3, 16'h0001);
  endtask

  task automatic testShl();
    runOp("R7", 1, 4'h7, 16'h8001, 16'h0004, 16'h0010, 1, 0, 2'd2, 16'h0008);
    runOp("R7", 1, 4'h7, 16'hABCD, 16'h0010, 16'h0000, 1, 0, 2'd2, 16'hABCD);
    runOp("R7", 1, 4'h7, 16'h0001, 16'h0028, 16'h0000, 1, 0, 2'd2, 16'h0000);
  endtask

  task automatic testShr();
    runOp("R8", 1, 4'h8, 16'h8001, 16'h0004, 16'h0800, 1, 0, 2'd2, 16'h1000);
    runOp("R8", 1, 4'h8, 16'h00FF, 16'h0014, 16'h0000, 1, 0, 2'd2, 16'h000F);
  endtask

  task automatic testLogic();
    runOp("R9", 1, 4'h3, 16'h0005, 16'h0007, 16'hFFFE, 1, 0, 2'd2, 16'hFFFF);
    runOp("R9", 1, 4'h1, 16'h1111, 16'hBEEF, 16'hBEEF, 1, 0, 2'd1, 16'hFFFF);
    runOp("R9", 1, 4'h9, 16'hF0F0, 16'h3C3C, 16'h3030, 1, 0, 2'd1, 16'hFFFF);
    runOp("R9", 1, 4'hA, 16'hF0F0, 16'h3C3C, 16'hFCFC, 1, 0, 2'd1, 16'hFFFF);
    runOp("R9", 1, 4'hB, 16'hF0F0, 16'h3C3C, 16'hCCCC, 1, 0, 2'd1, 16'hFFFF);
  endtask

  task automatic testCond();
    runOp("R10", 1, 4'hC, 16'h0005, 16'h0005, 16'h0000, 0, 1, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hC, 16'h0005, 16'h0006, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hD, 16'h0005, 16'h0006, 16'h0000, 0, 1, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hD, 16'h0007, 16'h0007, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hE, 16'h8000, 16'h7FFF, 16'h0000, 0, 1, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hE, 16'h7FFF, 16'h8000, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hF, 16'h00F0, 16'h0F00, 16'h0000, 0, 1, 2'd2, 16'hFFFF);
    runOp("R10", 1, 4'hF, 16'h00F0, 16'h0030, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
  endtask

  task automatic testEscape();
    runOp("R11", 1, 4'h0, 16'h1234, 16'h5678, 16'h0000, 0, 0, 2'd0, 16'hFFFF);
  endtask

  task automatic testIdle();
    runOp("R12", 0, 4'h2, 16'hFFFF, 16'h0001, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
    runOp("R12", 0, 4'hC, 16'h0005, 16'h0005, 16'h0000, 0, 0, 2'd2, 16'hFFFF);
    // R13: issued op right after idle updates ovf on the next edge
    runOp("R13", 1, 4'h2, 16'h0001, 16'h0001, 16'h0002, 1, 0, 2'd2, 16'h0000);
  endtask

  initial begin
    testReset();
    testAdd();
    testSub();
    testMul();
    testDiv();
    testMod();
    testShl();
    testShr();
    testLogic();
    testCond();
    testEscape();
    testIdle();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule